// File: doc/BRIEF.md
# Macroblock Coding Mode Decider

This block chooses how a 16x16 luma macroblock is coded in a motion-compensated video encoder. It takes the macroblock as a stream of 256 beats, each carrying one current-frame sample together with the co-located sample from the previously reconstructed frame. A separate motion search engine supplies its best compensated SAD on the final beat. From these inputs the block forms two activity measures. The first is the zero-displacement inter SAD. The second is an intra activity figure: the sum of absolute deviations of the current samples from their own mean.

The decision is a cascade of three fixed margins. If the zero-vector SAD is already small, the macroblock is marked as skipped. Otherwise the compensated SAD wins only when it beats the zero-vector SAD by a margin. Intra coding then wins only when the intra figure beats the selected inter SAD by a larger margin. The result is a two-bit mode code and the inter SAD that was selected, presented together with a one-cycle done strobe.

The mean is only known after the last sample arrives. The current samples are therefore kept in an internal buffer, and the deviation sum is formed in a second pass over that buffer.

Top module: `mb_mode_decider`

## Requirements
- R1: The intra figure is the sum over all samples of |sample - m|, where m is the sum of the 256 current samples shifted right by 8 bits (the truncated mean).
- R2: When the zero-vector SAD (sum of |cur - ref| over the macroblock) is below 100, mode is 2'b00 and inter_sad equals the zero-vector SAD, whatever mc_sad is.
- R3: Otherwise, when mc_sad + 100 is strictly less than the zero-vector SAD, the compensated SAD is selected: inter_sad equals mc_sad and mode is 2'b10 unless R5 applies.
- R4: Otherwise the zero-vector SAD is selected: inter_sad equals it and mode is 2'b01 unless R5 applies.
- R5: For a non-skipped macroblock, when the intra figure + 500 is strictly less than the selected inter SAD, mode is 2'b11 and inter_sad still reports the selected inter SAD.
- R6: done is high for exactly one cycle, on the clock edge 257 edges after the edge that captures the last beat. mode and inter_sad hold their values until the next done.
- R7: Beats presented after the last beat and before done, including ones marked first or last, are ignored.
- R8: A beat marked in_first restarts accumulation, so samples received since the previous decision without a last beat are discarded.
- R9: After reset, done is 0, mode is 2'b00 and inter_sad is 0.
- R10: mc_sad is sampled only on the beat that carries in_last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample pair present this cycle |
| in_first | input | 1 | Beat is the first sample of a macroblock |
| in_last | input | 1 | Beat is the last sample of a macroblock |
| cur_px | input | 8 | Current-frame luma sample |
| ref_px | input | 8 | Co-located sample of the previous reconstructed frame |
| mc_sad | input | 16 | Best motion-compensated SAD, valid with in_last |
| done | output | 1 | One-cycle strobe: decision valid |
| mode | output | 2 | 00 skip, 01 inter, 10 inter compensated, 11 intra |
| inter_sad | output | 16 | Selected inter SAD |

## Verification
The bench builds the block with its default values: 8-bit samples, 256 samples per macroblock, and margins of 100, 100 and 500. These values let flat fills and fills with a set total difference place the zero-vector SAD exactly on each threshold and one step to either side, so that every strict comparison is tested at its edge. A nearly flat fill whose sum is not a multiple of 256 exposes how the mean is rounded, and a ramp against its mirror pushes the intra figure far below the inter SAD. Junk beats during the second pass, and an abandoned partial macroblock, show that only framed beats count.

// File: rtl/mb_mode_decider.sv
module mb_mode_decider #(
  parameter int PIX_W        = 8,
  parameter int LOG2_N       = 8,
  parameter int SKIP_THR     = 100,
  parameter int MC_MARGIN    = 100,
  parameter int INTRA_MARGIN = 500
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic                      in_first,
  input  logic                      in_last,
  input  logic [PIX_W-1:0]          cur_px,
  input  logic [PIX_W-1:0]          ref_px,
  input  logic [PIX_W+LOG2_N-1:0]   mc_sad,
  output logic                      done,
  output logic [1:0]                mode,
  output logic [PIX_W+LOG2_N-1:0]   inter_sad
);

  localparam int N      = 1 << LOG2_N;
  localparam int ACC_W  = PIX_W + LOG2_N;
  localparam int CMP_W  = ACC_W + 2;
  localparam logic [LOG2_N-1:0] LAST_IDX = LOG2_N'(N - 1);

  typedef enum logic [1:0] {S_ACC, S_DEV, S_DEC} state_t;

  state_t              state;
  logic [LOG2_N-1:0]   wr_idx, rd_idx;
  logic [ACC_W-1:0]    sum_q, sad00_q, mc_q, dev_q;
  logic [PIX_W-1:0]    mem [N];

  wire                 accept   = (state == S_ACC) && in_valid;
  wire [LOG2_N-1:0]    beat_idx = in_first ? '0 : wr_idx;
  wire [ACC_W-1:0]     sum_base = in_first ? '0 : sum_q;
  wire [ACC_W-1:0]     sad_base = in_first ? '0 : sad00_q;
  wire [PIX_W-1:0]     pair_d   = (cur_px > ref_px) ? cur_px - ref_px : ref_px - cur_px;
  wire [PIX_W-1:0]     mean     = sum_q[ACC_W-1 -: PIX_W];
  wire [PIX_W-1:0]     rd_px    = mem[rd_idx];
  wire [PIX_W-1:0]     dev_d    = (rd_px > mean) ? rd_px - mean : mean - rd_px;

  wire [CMP_W-1:0]     s00_x    = CMP_W'(sad00_q);
  wire [CMP_W-1:0]     mc_x     = CMP_W'(mc_q);
  wire [CMP_W-1:0]     dev_x    = CMP_W'(dev_q);
  wire                 skip     = s00_x < CMP_W'(SKIP_THR);
  wire                 use_mc   = (mc_x + CMP_W'(MC_MARGIN)) < s00_x;
  wire [ACC_W-1:0]     sel_sad  = (!skip && use_mc) ? mc_q : sad00_q;
  wire                 go_intra = (dev_x + CMP_W'(INTRA_MARGIN)) < CMP_W'(sel_sad);
  wire [1:0]           mode_nx  = skip     ? 2'b00 :
                                  go_intra ? 2'b11 :
                                  use_mc   ? 2'b10 : 2'b01;

  always_ff @(posedge clk)
    if (accept) mem[beat_idx] <= cur_px;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_ACC;
      wr_idx    <= '0;
      rd_idx    <= '0;
      sum_q     <= '0;
      sad00_q   <= '0;
      mc_q      <= '0;
      dev_q     <= '0;
      done      <= 1'b0;
      mode      <= 2'b00;
      inter_sad <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_ACC: if (in_valid) begin
          wr_idx  <= beat_idx + 1'b1;
          sum_q   <= sum_base + ACC_W'(cur_px);
          sad00_q <= sad_base + ACC_W'(pair_d);
          if (in_last) begin
            mc_q   <= mc_sad;
            rd_idx <= '0;
            dev_q  <= '0;
            state  <= S_DEV;
          end
        end
        S_DEV: begin
          dev_q  <= dev_q + ACC_W'(dev_d);
          rd_idx <= rd_idx + 1'b1;
          if (rd_idx == LAST_IDX) state <= S_DEC;
        end
        S_DEC: begin
          done      <= 1'b1;
          mode      <= mode_nx;
          inter_sad <= sel_sad;
          state     <= S_ACC;
        end
        default: state <= S_ACC;
      endcase
    end
  end

  a_r2_skip_below_thr: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode == 2'b00 |-> CMP_W'(inter_sad) < CMP_W'(SKIP_THR));

  a_r4_inter_not_small: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode == 2'b01 |-> inter_sad == sad00_q && CMP_W'(inter_sad) >= CMP_W'(SKIP_THR));

  a_r3_mc_margin: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode == 2'b10 |-> (CMP_W'(inter_sad) + CMP_W'(MC_MARGIN)) < CMP_W'(sad00_q));

  a_r5_intra_margin: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode == 2'b11 |-> (CMP_W'(dev_q) + CMP_W'(INTRA_MARGIN)) < CMP_W'(inter_sad));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/test_mb_mode_decider.sv
module test_mb_mode_decider;
  localparam int CLK_PERIOD = 10;
  localparam int N = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [7:0]  cur_px = '0, ref_px = '0;
  logic [15:0] mc_sad = '0;
  logic        done;
  logic [1:0]  mode;
  logic [15:0] inter_sad;

  int checks = 0, fails = 0;
  int cyc = 0, last_cyc = 0;
  logic [7:0] cur_a [N];
  logic [7:0] ref_a [N];
  logic [1:0] q_mode [$];
  int         q_sad  [$];
  string      q_tag  [$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mb_mode_decider i_mb_mode_decider (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .cur_px(cur_px), .ref_px(ref_px), .mc_sad(mc_sad),
    .done(done), .mode(mode), .inter_sad(inter_sad)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void model(input int mc, output logic [1:0] m, output int isad);
    int sum = 0, mean, intra = 0, s00 = 0, sel;
    for (int i = 0; i < N; i++) begin
      sum += cur_a[i];
      s00 += (cur_a[i] > ref_a[i]) ? cur_a[i] - ref_a[i] : ref_a[i] - cur_a[i];
    end
    mean = sum / 256;
    for (int i = 0; i < N; i++)
      intra += (cur_a[i] > mean) ? cur_a[i] - mean : mean - cur_a[i];
    if (s00 < 100) begin
      m = 2'b00; isad = s00;
    end else begin
      if (mc + 100 < s00) begin sel = mc; m = 2'b10; end
      else begin sel = s00; m = 2'b01; end
      if (intra + 500 < sel) m = 2'b11;
      isad = sel;
    end
  endfunction

  task automatic fill_flat(input int v);
    for (int i = 0; i < N; i++) cur_a[i] = 8'(v);
  endtask

  task automatic set_ref(input int total);
    int rem = total, d;
    for (int i = 0; i < N; i++) begin
      d = (rem > 50) ? 50 : rem;
      rem -= d;
      ref_a[i] = (cur_a[i] >= 128) ? 8'(cur_a[i] - d) : 8'(cur_a[i] + d);
    end
  endtask

  task automatic send_mb(input int mc, input string tag, input bit junk);
    logic [1:0] m; int s;
    model(mc, m, s);
    q_mode.push_back(m); q_sad.push_back(s); q_tag.push_back(tag);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_first = (i == 0); in_last = (i == N - 1);
      cur_px = cur_a[i]; ref_px = ref_a[i];
      mc_sad = (i == N - 1) ? 16'(mc) : 16'hFFFF;
      if (i == N - 1) last_cyc = cyc + 1;
    end
    for (int i = 0; i < N + 4; i++) begin
      @(negedge clk);
      if (junk && i < N) begin
        in_valid = 1'b1; in_first = (i % 7 == 0); in_last = (i % 5 == 0);
        cur_px = 8'(i * 37); ref_px = 8'(255 - i); mc_sad = 16'(i);
      end else begin
        in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; mc_sad = 16'hFFFF;
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_mode.size() == 0) begin
        check(1'b0, "R7 unexpected done", 1, 0);
      end else begin
        logic [1:0] em; int es; string t;
        em = q_mode.pop_front(); es = q_sad.pop_front(); t = q_tag.pop_front();
        check(mode == em, {t, " mode"}, int'(mode), int'(em));
        check(int'(inter_sad) == es, {t, " inter_sad"}, int'(inter_sad), es);
        check(cyc - last_cyc == N + 1, "R6 latency", cyc - last_cyc, N + 1);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R9 done", int'(done), 0);
    check(mode == 2'b00, "R9 mode", int'(mode), 0);
    check(inter_sad == 16'd0, "R9 inter_sad", int'(inter_sad), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    fill_flat(128); set_ref(0);   send_mb(0, "R2 zero", 1'b0);
    fill_flat(128); set_ref(99);  send_mb(0, "R2 edge99", 1'b0);
    fill_flat(128); set_ref(100); send_mb(0, "R4 edge100", 1'b0);
    fill_flat(128); set_ref(200); send_mb(99, "R3/R10 mc99", 1'b0);
    repeat (20) @(negedge clk);
    check(mode == 2'b10, "R6 hold mode", int'(mode), 2);
    check(inter_sad == 16'd99, "R6 hold sad", int'(inter_sad), 99);
    fill_flat(128); set_ref(200); send_mb(100, "R4 mc100", 1'b0);
    fill_flat(128); set_ref(501); send_mb(2000, "R5 edge501", 1'b0);
    fill_flat(128); set_ref(500); send_mb(2000, "R5 edge500", 1'b0);

    fill_flat(10); cur_a[N-1] = 8'd11; set_ref(502); send_mb(9999, "R1 trunc502", 1'b0);
    fill_flat(10); cur_a[N-1] = 8'd11; set_ref(501); send_mb(9999, "R1 trunc501", 1'b0);

    for (int i = 0; i < N; i++) cur_a[i] = 8'(i);
    set_ref(12800); send_mb(20000, "R5 ramp", 1'b0);
    send_mb(100, "R3 ramp", 1'b0);
    for (int i = 0; i < N; i++) ref_a[i] = 8'(255 - i);
    send_mb(40000, "R5 mirror", 1'b0);

    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_first = (i == 0); in_last = 1'b0;
      cur_px = 8'd255; ref_px = 8'd0; mc_sad = 16'hFFFF;
    end
    @(negedge clk); in_valid = 1'b0; in_first = 1'b0;
    fill_flat(128); set_ref(99); send_mb(0, "R8 restart", 1'b0);

    fill_flat(128); set_ref(300); send_mb(50, "R7 busy", 1'b1);
    fill_flat(128); set_ref(120); send_mb(500, "R7 after", 1'b0);

    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < N; i++) begin
        cur_a[i] = 8'($urandom_range(0, 255));
        ref_a[i] = 8'($urandom_range(0, 255));
      end
      send_mb($urandom_range(0, 40000), "R4 random", 1'b0);
    end

    repeat (5) @(negedge clk);
    check(q_mode.size() == 0, "R6 missing done", q_mode.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule